// File: doc/BRIEF.md
# Flash Erase Block Selector

This block holds the choice of which single flash block may be erased. Software sees two byte-wide registers, a low one for blocks 0 to 7 and a high one for blocks 8 to 15, through a small register bus with a one-bit address, a write strobe, write data and combinational read data. Together the two registers drive a 16-bit erase-permit vector. This vector is either all zero or has exactly one bit set, and the flash erase logic downstream uses it directly.

Hardware conditions override what software writes. These conditions are power-on reset, the two standby indications, the flash write-enable pin and the two software write-enable bits. When a write would enable two or more blocks at once, every block is deselected instead. When the on-chip flash is switched off, the registers read as zero and ignore writes.

Top module: `erase_sel`

## Requirements
- R1: While `por_n` is low, both registers and `erase_permit` are zero at once, without waiting for a clock edge.
- R2: A clock edge with `hw_stby` or `sw_stby` high leaves all 16 bits at zero.
- R3: A clock edge with `fwe` low leaves all 16 bits at zero.
- R4: While `fwe` is high and `swe1` is low, the low register (bits 7..0) and high-register bits 3..0 (blocks 8..11) are held at zero. High-register bits 7..4 stay writable.
- R5: While `fwe` is high and `swe2` is low, high-register bits 7..4 (blocks 12..15) are held at zero. Bits 3..0 stay writable.
- R6: A write with `wr_en` high stores `wdata` on the clock edge. `sel`=0 addresses the low register and `sel`=1 the high one. `rdata` returns the register picked by `sel` in the same cycle, and `erase_permit` equals {high, low}.
- R7: If the 16-bit value after a write, taking the untouched register and the R4/R5 holds into account, would have two or more bits set, all 16 bits clear on that same edge.
- R8: Writing 0x00 to either register always succeeds and deselects that register's blocks.
- R9: While `flash_on` is low, `rdata` is 0x00 and writes leave the stored bits unchanged. The stored value is visible again once `flash_on` returns high.
- R10: The clear and hold conditions of R2 to R5 win over a bus write made on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| hw_stby | input | 1 | Hardware standby indication |
| sw_stby | input | 1 | Software standby indication |
| fwe | input | 1 | Flash write-enable pin level |
| swe1 | input | 1 | Software write-enable bit for blocks 0..11 |
| swe2 | input | 1 | Software write-enable bit for blocks 12..15 |
| flash_on | input | 1 | On-chip flash enabled |
| sel | input | 1 | Register address: 0 low, 1 high |
| wr_en | input | 1 | Write strobe |
| wdata | input | REG_W | Write data |
| rdata | output | REG_W | Read data of the selected register |
| erase_permit | output | 2*REG_W | Erase-permit vector, zero or one-hot |

## Verification
The bench builds the block with the default `REG_W` of 8. At that width the two registers make up the 16 permit bits and each hold group is four bits wide. This puts every bit position, both group boundaries (bits 7/8 and 11/12) and two-bit collisions within one register and across the two registers within reach of byte writes. Directed sequences then place the hold inputs against writes to the held groups. This shows that a write masked by a hold cannot trigger the multi-bit clear.

// File: rtl/erase_sel.sv
module erase_sel #(
  parameter int REG_W = 8
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               hw_stby,
  input  logic               sw_stby,
  input  logic               fwe,
  input  logic               swe1,
  input  logic               swe2,
  input  logic               flash_on,
  input  logic               sel,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   rdata,
  output logic [2*REG_W-1:0] erase_permit
);
  localparam int TOT_W = 2 * REG_W;
  localparam int HALF  = REG_W / 2;

  logic [REG_W-1:0] lo_q, hi_q, lo_w, hi_w, lo_d, hi_d;
  logic [TOT_W-1:0] cand, next;
  logic             wipe, multi;

  assign wipe = hw_stby | sw_stby | ~fwe;

  always_comb begin
    lo_w = lo_q;
    hi_w = hi_q;
    if (wr_en && flash_on) begin
      if (sel) hi_w = wdata;
      else     lo_w = wdata;
    end
    lo_d = lo_w;
    hi_d = hi_w;
    if (!swe1) begin
      lo_d            = '0;
      hi_d[HALF-1:0]  = '0;
    end
    if (!swe2) hi_d[REG_W-1:HALF] = '0;
  end

  assign cand  = {hi_d, lo_d};
  assign multi = |(cand & (cand - {{(TOT_W-1){1'b0}}, 1'b1}));
  assign next  = multi ? '0 : cand;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (wipe) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      {hi_q, lo_q} <= next;
    end
  end

  assign rdata        = flash_on ? (sel ? hi_q : lo_q) : '0;
  assign erase_permit = {hi_q, lo_q};

  // R7
  permit_onehot_chk: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0(erase_permit));

  // R2
  stby_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    (hw_stby || sw_stby) |=> erase_permit == '0);

  // R3
  fwe_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    !fwe |=> erase_permit == '0);

  // R4
  swe1_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    !swe1 |=> erase_permit[REG_W+HALF-1:0] == '0);

  // R5
  swe2_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    !swe2 |=> erase_permit[TOT_W-1:REG_W+HALF] == '0);

  // R9
  off_read_chk: assert property (@(posedge clk) disable iff (!por_n)
    !flash_on |-> rdata == '0);

  // R9
  off_nowrite_chk: assert property (@(posedge clk) disable iff (!por_n)
    !flash_on |=> (erase_permit & ~$past(erase_permit)) == '0);
endmodule

// File: tb/sim_erase_sel.sv
module sim_erase_sel;
  logic        clk = 0, por_n = 0, hw_stby = 0, sw_stby = 0, fwe = 1;
  logic        swe1 = 1, swe2 = 1, flash_on = 1, sel = 0, wr_en = 0;
  logic [7:0]  wdata = 0, rdata;
  logic [15:0] erase_permit;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  erase_sel u0 (.clk, .por_n, .hw_stby, .sw_stby, .fwe, .swe1, .swe2,
                .flash_on, .sel, .wr_en, .wdata, .rdata, .erase_permit);

  // {sel, wdata, expected permit after write}, all enables active
  localparam logic [24:0] VEC [10] = '{
    {1'b0, 8'h01, 16'h0001},  // R6
    {1'b0, 8'h80, 16'h0080},  // R6
    {1'b1, 8'h01, 16'h0000},  // R7 across registers
    {1'b1, 8'h10, 16'h1000},  // R6
    {1'b1, 8'h00, 16'h0000},  // R8
    {1'b0, 8'h03, 16'h0000},  // R7 within a register
    {1'b0, 8'h04, 16'h0004},  // R6
    {1'b0, 8'h00, 16'h0000},  // R8
    {1'b1, 8'h80, 16'h8000},  // R6
    {1'b0, 8'h02, 16'h0000}   // R7
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    sel = s; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input string req, input logic s, input logic [7:0] exp);
    sel = s; #1;
    chk(req, {8'h00, rdata}, {8'h00, exp});
  endtask

  initial begin
    #5;
    chk("R1", erase_permit, 16'h0000);
    @(negedge clk); por_n = 1; @(negedge clk);
    rd("R1", 0, 8'h00);
    rd("R1", 1, 8'h00);

    foreach (VEC[i]) begin
      wr(VEC[i][24], VEC[i][23:16]);
      chk("R6/R7/R8 table", erase_permit, VEC[i][15:0]);
      rd("R6 readback", 0, VEC[i][7:0]);
      rd("R6 readback", 1, VEC[i][15:8]);
    end

    wr(0, 8'h00); wr(1, 8'h00);
    wr(0, 8'h04);
    hw_stby = 1; @(negedge clk); hw_stby = 0;
    chk("R2 hw", erase_permit, 16'h0000);
    wr(1, 8'h02);
    sw_stby = 1; @(negedge clk); sw_stby = 0;
    chk("R2 sw", erase_permit, 16'h0000);
    hw_stby = 1; wr(0, 8'h01); hw_stby = 0;
    chk("R10 stby vs write", erase_permit, 16'h0000);

    wr(0, 8'h08);
    fwe = 0; @(negedge clk);
    chk("R3", erase_permit, 16'h0000);
    wr(0, 8'h01);
    chk("R10 fwe vs write", erase_permit, 16'h0000);
    fwe = 1;

    wr(0, 8'h08);
    swe1 = 0; @(negedge clk);
    chk("R4 drop clears", erase_permit, 16'h0000);
    wr(0, 8'h01);
    chk("R4 low held", erase_permit, 16'h0000);
    wr(1, 8'h08);
    chk("R4 EB11 held", erase_permit, 16'h0000);
    wr(1, 8'h10);
    chk("R4 upper group free", erase_permit, 16'h1000);
    swe1 = 1; wr(1, 8'h00);

    swe2 = 0;
    wr(1, 8'h20);
    chk("R5 upper held", erase_permit, 16'h0000);
    wr(1, 8'h02);
    chk("R5 lower group free", erase_permit, 16'h0200);
    wr(1, 8'h00);
    wr(0, 8'h01);
    wr(1, 8'h40);
    chk("R7 held bits do not collide", erase_permit, 16'h0001);
    swe2 = 1;

    wr(0, 8'h04);
    flash_on = 0;
    rd("R9 read zero lo", 0, 8'h00);
    rd("R9 read zero hi", 1, 8'h00);
    @(negedge clk);
    wr(0, 8'h00);
    wr(1, 8'h80);
    chk("R9 writes ignored", erase_permit, 16'h0004);
    flash_on = 1; @(negedge clk);
    rd("R9 value back", 0, 8'h04);

    wr(1, 8'h00);
    chk("R8 zero to other reg", erase_permit, 16'h0004);
    #3 por_n = 0; #2;
    chk("R1 async", erase_permit, 16'h0000);
    @(negedge clk); por_n = 1; @(negedge clk);
    chk("R1 after", erase_permit, 16'h0000);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end
endmodule